// File: doc/BRIEF.md
# Radio Transceiver Sequencing FSM

This block is the control state machine in the digital back end of a packet radio. A CPU gives it three command strobes: start receive, start transmit and go idle. The block then runs each step in the right order. Every time the receiver or the transmitter is about to be enabled, it first runs a synthesizer calibration handshake. In receive, it takes the frame length from the demodulator and moves that many bytes into a receive FIFO. It then checks the frame check sequence and, when enabled, sends an acknowledgment on its own.

In transmit, it can first request a clear-channel assessment and abort if the channel is busy. It then streams the bytes of the transmit FIFO to the modulator. When the stream ends, it turns around into receive so that it can catch an acknowledgment. The calibration, the channel assessment and the modem appear only as handshake and strobe ports. Single-cycle status pulses report frame boundaries and errors, and two level outputs report receive and transmit activity.

Top module: `radio_seq_fsm`

## Requirements
- R1: After a receive or transmit command, and before every automatic turnaround or acknowledgment, cal_req_o stays high until cal_done_i. Neither rx_active_o nor tx_active_o rises before cal_done_i is seen.
- R2: cmd_idle_i returns the block to idle from any state and wins over the other strobes. cmd_tx_i is taken in idle or while listening, and wins over cmd_rx_i. cmd_rx_i is taken only in idle. Any other strobe has no effect.
- R3: While listening, rx_sfd_i starts a frame and sfd_seen_o pulses high for one cycle on the next cycle. The next byte with rx_valid_i high is the length L, which counts the payload bytes plus the two FCS bytes.
- R4: The L bytes that follow are written to the receive FIFO in arrival order. Cycles with rx_valid_i low are skipped. rxf_data_o shows the oldest byte, and rxf_rd_i removes it.
- R5: The cycle after the L-th byte, frame_done_o is high for exactly one cycle. In that cycle frame_ok_o is high only if a CRC-16 over all L bytes gives zero. The CRC uses polynomial x^16+x^12+x^5+1, starts from zero, processes bits LSB first, and expects the FCS low byte first.
- R6: If the frame is good and auto_ack_en_i is high, the block calibrates and then sends two bytes: 8'h02, then the first payload byte. Each byte is held on tx_byte_o until tx_ready_i. The block then calibrates and returns to listening. Otherwise it goes straight back to listening.
- R7: With cca_en_i high, a transmit holds cca_req_o high after calibration until cca_done_i. If cca_clear_i is high, transmission starts. If not, tx_aborted_o pulses for one cycle, no byte leaves the transmit FIFO, and the block calibrates back into receive. With cca_en_i low, transmission starts right after calibration.
- R8: Transmission presents the bytes of the transmit FIFO in write order. tx_valid_o is high while the FIFO holds data, and each byte leaves on tx_valid_o and tx_ready_i. When the FIFO is empty, the block calibrates and then listens.
- R9: A length byte above 127 discards the frame. rx_overflow_o pulses for one cycle, the receive FIFO is emptied, and the block listens again.
- R10: A payload byte that arrives while the receive FIFO is full causes the same discard, pulse and flush as R9.
- R11: Each FIFO holds 128 bytes. A write to a full transmit FIFO is dropped.
- R12: rx_active_o is high while listening, receiving or checking. tx_active_o is high while data or an acknowledgment is being sent. The two are never high together.
- R13: After reset the block is idle. All status and request outputs are low, the receive FIFO is empty and the transmit FIFO is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_rx_i | input | 1 | Strobe: start receive |
| cmd_tx_i | input | 1 | Strobe: start transmit |
| cmd_idle_i | input | 1 | Strobe: go idle |
| auto_ack_en_i | input | 1 | Send an acknowledgment after a good frame |
| cca_en_i | input | 1 | Gate transmission on a channel assessment |
| cal_req_o | output | 1 | Calibration requested |
| cal_done_i | input | 1 | Calibration finished |
| cca_req_o | output | 1 | Channel assessment requested |
| cca_done_i | input | 1 | Channel assessment finished |
| cca_clear_i | input | 1 | Assessment result, high when the channel is clear |
| rx_sfd_i | input | 1 | Frame start detected by the demodulator |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Byte offered to the modulator |
| tx_byte_o | output | 8 | Byte to the modulator |
| tx_ready_i | input | 1 | Modulator takes the byte |
| txf_wr_i | input | 1 | Transmit FIFO write |
| txf_data_i | input | 8 | Transmit FIFO write data |
| txf_full_o | output | 1 | Transmit FIFO full |
| rxf_rd_i | input | 1 | Receive FIFO read |
| rxf_data_o | output | 8 | Oldest byte in the receive FIFO |
| rxf_empty_o | output | 1 | Receive FIFO empty |
| sfd_seen_o | output | 1 | Pulse: frame start accepted |
| rx_active_o | output | 1 | Receiver enabled |
| tx_active_o | output | 1 | Transmitter sending |
| frame_done_o | output | 1 | Pulse: frame complete |
| frame_ok_o | output | 1 | FCS good, valid with frame_done_o |
| tx_aborted_o | output | 1 | Pulse: transmit aborted on a busy channel |
| rx_overflow_o | output | 1 | Pulse: frame discarded, receive FIFO flushed |

## Verification
The assertions assume that the handshake inputs keep to their requests. cal_done_i and cca_done_i are high only while cal_req_o or cca_req_o asks for them, and tx_ready_i does not affect an offered byte except by taking it. The bench raises each done strobe for one cycle, and only after it has seen the matching request. It drives demodulator bytes only after a frame start that it has seen accepted. It raises cmd_idle_i only between frames, so the check that an offered byte stays stable never sees a byte withdrawn under it.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAL,
    ST_LISTEN,
    ST_RX_LEN,
    ST_RX_DATA,
    ST_RX_CHECK,
    ST_CCA,
    ST_TX_DATA,
    ST_ACK_DATA
  } seq_state_e;

  typedef enum logic [1:0] {
    TGT_RX,
    TGT_TX,
    TGT_ACK
  } cal_tgt_e;

  // reflected CRC-16, LSB of the byte first
  function automatic logic [15:0] crc16_step(logic [15:0] crc, logic [BYTE_W-1:0] b,
                                             logic [15:0] poly_r);
    logic [15:0] c;
    logic fb;
    c = crc;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ poly_r;
    end
    return c;
  endfunction

endpackage

// File: rtl/rs_crc16.sv
module rs_crc16
  import radio_seq_pkg::*;
#(
  parameter logic [15:0] POLY_R = 16'h8408
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [15:0]       crc_o
);

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc16_step(crc_q, data_i, POLY_R);
  end

  assign crc_o = crc_q;

  assert_clr_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == 16'h0000));

endmodule

// File: rtl/rs_fifo.sv
module rs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = wr_i && !full_o && !flush_i;
  assign rd_ok   = rd_i && !empty_o && !flush_i;
  assign rdata_o = mem[rptr_q];

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wptr_q <= ptr_inc(wptr_q);
      if (rd_ok) rptr_q <= ptr_inc(rptr_q);
      if (wr_ok && !rd_ok)      cnt_q <= cnt_q + 1'b1;
      else if (rd_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i && !flush_i) |=> full_o);

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

endmodule

// File: rtl/radio_seq_fsm.sv
module radio_seq_fsm
  import radio_seq_pkg::*;
#(
  parameter int                FIFO_DEPTH = 128,
  parameter int                MAX_LEN    = 127,
  parameter logic [BYTE_W-1:0] ACK_CODE   = 8'h02,
  parameter logic [15:0]       CRC_POLY_R = 16'h8408
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_rx_i,
  input  logic              cmd_tx_i,
  input  logic              cmd_idle_i,
  input  logic              auto_ack_en_i,
  input  logic              cca_en_i,
  output logic              cal_req_o,
  input  logic              cal_done_i,
  output logic              cca_req_o,
  input  logic              cca_done_i,
  input  logic              cca_clear_i,
  input  logic              rx_sfd_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              tx_ready_i,
  input  logic              txf_wr_i,
  input  logic [BYTE_W-1:0] txf_data_i,
  output logic              txf_full_o,
  input  logic              rxf_rd_i,
  output logic [BYTE_W-1:0] rxf_data_o,
  output logic              rxf_empty_o,
  output logic              sfd_seen_o,
  output logic              rx_active_o,
  output logic              tx_active_o,
  output logic              frame_done_o,
  output logic              frame_ok_o,
  output logic              tx_aborted_o,
  output logic              rx_overflow_o
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);

  seq_state_e        state_q, state_d;
  cal_tgt_e          tgt_q, tgt_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] seq_q, seq_d;
  logic              first_q, first_d;
  logic              ack_idx_q, ack_idx_d;
  logic              sfd_q, sfd_d, abort_q, abort_d, ovf_q, ovf_d;

  logic              rxf_push, rxf_flush, rxf_full;
  logic              txf_pop, txf_empty;
  logic [BYTE_W-1:0] txf_head;
  logic              crc_clr, crc_en;
  logic [15:0]       crc;
  logic              crc_good;

  rs_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rxf_flush),
    .wr_i    (rxf_push),
    .wdata_i (rx_byte_i),
    .rd_i    (rxf_rd_i),
    .rdata_o (rxf_data_o),
    .full_o  (rxf_full),
    .empty_o (rxf_empty_o)
  );

  rs_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (1'b0),
    .wr_i    (txf_wr_i),
    .wdata_i (txf_data_i),
    .rd_i    (txf_pop),
    .rdata_o (txf_head),
    .full_o  (txf_full_o),
    .empty_o (txf_empty)
  );

  rs_crc16 #(.POLY_R(CRC_POLY_R)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .data_i (rx_byte_i),
    .crc_o  (crc)
  );

  assign crc_good = (crc == 16'h0000);

  always_comb begin
    state_d   = state_q;
    tgt_d     = tgt_q;
    cnt_d     = cnt_q;
    seq_d     = seq_q;
    first_d   = first_q;
    ack_idx_d = ack_idx_q;
    sfd_d     = 1'b0;
    abort_d   = 1'b0;
    ovf_d     = 1'b0;
    rxf_push  = 1'b0;
    rxf_flush = 1'b0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    txf_pop   = 1'b0;

    if (cmd_idle_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_tx_i) begin
            state_d = ST_CAL;
            tgt_d   = TGT_TX;
          end else if (cmd_rx_i) begin
            state_d = ST_CAL;
            tgt_d   = TGT_RX;
          end
        end
        ST_CAL: begin
          if (cal_done_i) begin
            unique case (tgt_q)
              TGT_TX:  state_d = cca_en_i ? ST_CCA : ST_TX_DATA;
              TGT_ACK: begin
                state_d   = ST_ACK_DATA;
                ack_idx_d = 1'b0;
              end
              default: state_d = ST_LISTEN;
            endcase
          end
        end
        ST_LISTEN: begin
          if (cmd_tx_i) begin
            state_d = ST_CAL;
            tgt_d   = TGT_TX;
          end else if (rx_sfd_i) begin
            state_d = ST_RX_LEN;
            sfd_d   = 1'b1;
            crc_clr = 1'b1;
          end
        end
        ST_RX_LEN: begin
          if (rx_valid_i) begin
            if (rx_byte_i > BYTE_W'(MAX_LEN)) begin
              ovf_d     = 1'b1;
              rxf_flush = 1'b1;
              state_d   = ST_LISTEN;
            end else if (rx_byte_i == '0) begin
              state_d = ST_RX_CHECK;
            end else begin
              cnt_d   = rx_byte_i[LEN_W-1:0];
              first_d = 1'b1;
              state_d = ST_RX_DATA;
            end
          end
        end
        ST_RX_DATA: begin
          if (rx_valid_i) begin
            if (rxf_full) begin
              ovf_d     = 1'b1;
              rxf_flush = 1'b1;
              state_d   = ST_LISTEN;
            end else begin
              rxf_push = 1'b1;
              crc_en   = 1'b1;
              first_d  = 1'b0;
              if (first_q) seq_d = rx_byte_i;
              cnt_d = cnt_q - 1'b1;
              if (cnt_q == LEN_W'(1)) state_d = ST_RX_CHECK;
            end
          end
        end
        ST_RX_CHECK: begin
          if (crc_good && auto_ack_en_i) begin
            state_d = ST_CAL;
            tgt_d   = TGT_ACK;
          end else begin
            state_d = ST_LISTEN;
          end
        end
        ST_CCA: begin
          if (cca_done_i) begin
            if (cca_clear_i) begin
              state_d = ST_TX_DATA;
            end else begin
              abort_d = 1'b1;
              state_d = ST_CAL;
              tgt_d   = TGT_RX;
            end
          end
        end
        ST_TX_DATA: begin
          if (txf_empty) begin
            state_d = ST_CAL;
            tgt_d   = TGT_RX;
          end else if (tx_ready_i) begin
            txf_pop = 1'b1;
          end
        end
        ST_ACK_DATA: begin
          if (tx_ready_i) begin
            if (ack_idx_q) begin
              state_d = ST_CAL;
              tgt_d   = TGT_RX;
            end else begin
              ack_idx_d = 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tgt_q     <= TGT_RX;
      cnt_q     <= '0;
      seq_q     <= '0;
      first_q   <= 1'b0;
      ack_idx_q <= 1'b0;
      sfd_q     <= 1'b0;
      abort_q   <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_q     <= tgt_d;
      cnt_q     <= cnt_d;
      seq_q     <= seq_d;
      first_q   <= first_d;
      ack_idx_q <= ack_idx_d;
      sfd_q     <= sfd_d;
      abort_q   <= abort_d;
      ovf_q     <= ovf_d;
    end
  end

  assign cal_req_o     = (state_q == ST_CAL);
  assign cca_req_o     = (state_q == ST_CCA);
  assign rx_active_o   = (state_q == ST_LISTEN) || (state_q == ST_RX_LEN) ||
                         (state_q == ST_RX_DATA) || (state_q == ST_RX_CHECK);
  assign tx_active_o   = (state_q == ST_TX_DATA) || (state_q == ST_ACK_DATA);
  assign tx_valid_o    = ((state_q == ST_TX_DATA) && !txf_empty) || (state_q == ST_ACK_DATA);
  assign tx_byte_o     = (state_q == ST_ACK_DATA) ? (ack_idx_q ? seq_q : ACK_CODE) : txf_head;
  assign frame_done_o  = (state_q == ST_RX_CHECK);
  assign frame_ok_o    = frame_done_o && crc_good;
  assign sfd_seen_o    = sfd_q;
  assign tx_aborted_o  = abort_q;
  assign rx_overflow_o = ovf_q;

  assert_cal_before_rx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_active_o) |-> $past(cal_req_o && cal_done_i));

  assert_cal_before_tx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> ($past(cal_req_o && cal_done_i) ||
                            $past(cca_req_o && cca_done_i && cca_clear_i)));

  assert_sfd_in_rx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_seen_o |-> rx_active_o);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  assert_abort_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_aborted_o |-> (!tx_active_o && !cca_req_o));

  assert_tx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !cmd_idle_i) |=> (tx_valid_o && $stable(tx_byte_o)));

  assert_ovf_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overflow_o |-> (rxf_empty_o && !frame_done_o));

  assert_one_dir_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_active_o && tx_active_o));

endmodule

// File: tb/radio_seq_fsm_tb.sv
module radio_seq_fsm_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ACK_CODE = 8'h02;

  typedef struct packed {
    logic [6:0] len;
    logic [7:0] seed;
    logic       bad;
    logic       ack;
    logic       ok;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'd5,   8'h11, 1'b0, 1'b1, 1'b1},
    '{7'd4,   8'h40, 1'b1, 1'b1, 1'b0},
    '{7'd2,   8'h00, 1'b0, 1'b1, 1'b1},
    '{7'd127, 8'h3c, 1'b0, 1'b0, 1'b1},
    '{7'd9,   8'ha5, 1'b0, 1'b0, 1'b1},
    '{7'd6,   8'h77, 1'b1, 1'b0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_rx_i = 0, cmd_tx_i = 0, cmd_idle_i = 0;
  logic auto_ack_en_i = 0, cca_en_i = 0;
  logic cal_done_i = 0, cca_done_i = 0, cca_clear_i = 0;
  logic rx_sfd_i = 0, rx_valid_i = 0;
  logic [7:0] rx_byte_i = '0;
  logic tx_ready_i = 0;
  logic txf_wr_i = 0;
  logic [7:0] txf_data_i = '0;
  logic rxf_rd_i = 0;
  logic cal_req_o, cca_req_o, tx_valid_o, txf_full_o, rxf_empty_o;
  logic [7:0] tx_byte_o, rxf_data_o;
  logic sfd_seen_o, rx_active_o, tx_active_o, frame_done_o, frame_ok_o;
  logic tx_aborted_o, rx_overflow_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] frm [128];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  radio_seq_fsm u_dut (
    .clk_i, .rst_ni, .cmd_rx_i, .cmd_tx_i, .cmd_idle_i, .auto_ack_en_i, .cca_en_i,
    .cal_req_o, .cal_done_i, .cca_req_o, .cca_done_i, .cca_clear_i,
    .rx_sfd_i, .rx_valid_i, .rx_byte_i, .tx_valid_o, .tx_byte_o, .tx_ready_i,
    .txf_wr_i, .txf_data_i, .txf_full_o, .rxf_rd_i, .rxf_data_o, .rxf_empty_o,
    .sfd_seen_o, .rx_active_o, .tx_active_o, .frame_done_o, .frame_ok_o,
    .tx_aborted_o, .rx_overflow_o
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic build(input int len, input logic [7:0] seed, input logic bad);
    logic [15:0] c;
    c = '0;
    for (int i = 0; i < len - 2; i++) begin
      frm[i] = seed + 8'(i * 7);
      c = crc_upd(c, frm[i]);
    end
    frm[len-2] = c[7:0];
    frm[len-1] = c[15:8];
    if (bad) frm[0] = frm[0] ^ 8'h01;
  endtask

  task automatic cal_ok();
    cal_done_i = 1;
    tick();
    cal_done_i = 0;
  endtask

  task automatic rx_frame(input int len);
    rx_sfd_i = 1;
    tick();
    rx_sfd_i = 0;
    chk("R3 sfd_seen pulse", sfd_seen_o, 1);
    rx_valid_i = 1;
    rx_byte_i  = 8'(len);
    tick();
    chk("R3 sfd_seen one cycle", sfd_seen_o, 0);
    for (int i = 0; i < len; i++) begin
      if (i == 1) begin
        rx_valid_i = 0;
        rx_byte_i  = 8'hee;
        tick();
        chk("R4 gap no done", frame_done_o, 0);
      end
      rx_valid_i = 1;
      rx_byte_i  = frm[i];
      tick();
    end
    rx_valid_i = 0;
  endtask

  task automatic drain(input int len);
    int errs;
    errs = 0;
    for (int i = 0; i < len; i++) begin
      if (rxf_data_o !== frm[i] || rxf_empty_o) errs++;
      rxf_rd_i = 1;
      tick();
      rxf_rd_i = 0;
    end
    chk("R4 fifo byte order", errs, 0);
    chk("R4 fifo empty after frame", rxf_empty_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick();
    tick();
    rst_ni = 1;
    tick();
    // R13 reset state
    chk("R13 cal_req", cal_req_o, 0);
    chk("R13 cca_req", cca_req_o, 0);
    chk("R13 rx_active", rx_active_o, 0);
    chk("R13 tx_active", tx_active_o, 0);
    chk("R13 tx_valid", tx_valid_o, 0);
    chk("R13 pulses", {sfd_seen_o, frame_done_o, tx_aborted_o, rx_overflow_o}, 0);
    chk("R13 rxf empty", rxf_empty_o, 1);
    chk("R13 txf not full", txf_full_o, 0);

    // R1 calibration gates receive
    cmd_rx_i = 1;
    tick();
    cmd_rx_i = 0;
    repeat (3) tick();
    chk("R1 cal_req held", cal_req_o, 1);
    chk("R1 rx off during cal", rx_active_o, 0);
    cal_ok();
    chk("R1 rx on after cal", rx_active_o, 1);
    chk("R12 rx only", tx_active_o, 0);

    // receive table
    foreach (VECS[v]) begin
      auto_ack_en_i = VECS[v].ack;
      build(int'(VECS[v].len), VECS[v].seed, VECS[v].bad);
      rx_frame(int'(VECS[v].len));
      chk("R5 frame_done", frame_done_o, 1);
      chk("R5 frame_ok", frame_ok_o, VECS[v].ok);
      tick();
      chk("R5 done one cycle", frame_done_o, 0);
      if (VECS[v].ok && VECS[v].ack) begin
        chk("R1 cal before ack", cal_req_o, 1);
        chk("R1 no tx before cal", tx_active_o, 0);
        cal_ok();
        chk("R6 ack valid", tx_valid_o, 1);
        chk("R6 ack code", tx_byte_o, ACK_CODE);
        chk("R12 tx only", rx_active_o, 0);
        tick();
        chk("R6 ack code held", tx_byte_o, ACK_CODE);
        tx_ready_i = 1;
        tick();
        chk("R6 ack seq byte", tx_byte_o, frm[0]);
        tick();
        tx_ready_i = 0;
        chk("R6 turnaround cal", cal_req_o, 1);
        cal_ok();
      end
      chk("R6 back to listen", rx_active_o, 1);
      chk("R6 no cal on listen", cal_req_o, 0);
      drain(int'(VECS[v].len));
    end
    auto_ack_en_i = 0;

    // R2 ignored commands while listening, idle priority
    cmd_rx_i = 1;
    tick();
    cmd_rx_i = 0;
    chk("R2 cmd_rx ignored in listen", {rx_active_o, cal_req_o}, 2'b10);
    cmd_idle_i = 1;
    cmd_tx_i   = 1;
    tick();
    cmd_idle_i = 0;
    cmd_tx_i   = 0;
    chk("R2 idle wins", {rx_active_o, cal_req_o, tx_active_o}, 3'b000);

    // R11 transmit FIFO depth, R7 clear channel, R8 streaming
    for (int i = 0; i < 130; i++) begin
      txf_wr_i   = 1;
      txf_data_i = 8'(i * 3 + 1);
      tick();
    end
    txf_wr_i = 0;
    chk("R11 txf full", txf_full_o, 1);
    cmd_tx_i = 1;
    cmd_rx_i = 1;
    tick();
    cmd_tx_i = 0;
    cmd_rx_i = 0;
    chk("R2 tx over rx cal", cal_req_o, 1);
    cca_en_i = 1;
    cal_ok();
    chk("R7 cca_req", cca_req_o, 1);
    chk("R7 no tx before cca", tx_active_o, 0);
    cca_done_i  = 1;
    cca_clear_i = 1;
    tick();
    cca_done_i  = 0;
    cca_clear_i = 0;
    chk("R7 tx after clear", tx_active_o, 1);
    begin
      int errs;
      errs = 0;
      tx_ready_i = 1;
      for (int k = 0; k < 128; k++) begin
        if (!tx_valid_o || tx_byte_o !== 8'(k * 3 + 1)) errs++;
        tick();
      end
      chk("R8 tx byte order", errs, 0);
      chk("R11 only 128 bytes kept", tx_valid_o, 0);
      tick();
      tx_ready_i = 0;
    end
    chk("R8 turnaround cal", cal_req_o, 1);
    chk("R8 tx off", tx_active_o, 0);
    cal_ok();
    chk("R8 listen after tx", rx_active_o, 1);

    // R7 busy channel abort, then plain transmit
    txf_wr_i = 1;
    txf_data_i = 8'h5a;
    tick();
    txf_data_i = 8'hc3;
    tick();
    txf_wr_i = 0;
    cmd_tx_i = 1;
    tick();
    cmd_tx_i = 0;
    chk("R2 tx from listen", cal_req_o, 1);
    cal_ok();
    cca_done_i  = 1;
    cca_clear_i = 0;
    tick();
    cca_done_i = 0;
    chk("R7 aborted pulse", tx_aborted_o, 1);
    chk("R7 no tx on busy", tx_active_o, 0);
    chk("R7 cal toward rx", cal_req_o, 1);
    tick();
    chk("R7 abort one cycle", tx_aborted_o, 0);
    cal_ok();
    chk("R7 rx after abort", rx_active_o, 1);
    cca_en_i = 0;
    cmd_tx_i = 1;
    tick();
    cmd_tx_i = 0;
    cal_ok();
    chk("R7 no cca when disabled", {cca_req_o, tx_active_o}, 2'b01);
    chk("R7 fifo untouched by abort", tx_byte_o, 8'h5a);
    tx_ready_i = 1;
    tick();
    chk("R8 second byte", tx_byte_o, 8'hc3);
    tick();
    tick();
    tx_ready_i = 0;
    cal_ok();
    chk("R8 listen again", rx_active_o, 1);

    // R9 oversize length
    build(3, 8'h21, 1'b0);
    rx_frame(3);
    tick();
    chk("R9 stale frame kept", rxf_empty_o, 0);
    rx_sfd_i = 1;
    tick();
    rx_sfd_i   = 0;
    rx_valid_i = 1;
    rx_byte_i  = 8'd200;
    tick();
    rx_valid_i = 0;
    chk("R9 overflow pulse", rx_overflow_o, 1);
    chk("R9 fifo flushed", rxf_empty_o, 1);
    chk("R9 listening", rx_active_o, 1);
    tick();
    chk("R9 pulse one cycle", rx_overflow_o, 0);

    // R10 receive FIFO full mid-frame
    build(127, 8'h09, 1'b0);
    rx_frame(127);
    tick();
    build(3, 8'h33, 1'b0);
    rx_sfd_i = 1;
    tick();
    rx_sfd_i   = 0;
    rx_valid_i = 1;
    rx_byte_i  = 8'd3;
    tick();
    rx_byte_i = frm[0];
    tick();
    chk("R10 no overflow at 128", rx_overflow_o, 0);
    rx_byte_i = frm[1];
    tick();
    rx_valid_i = 0;
    chk("R10 overflow on full", rx_overflow_o, 1);
    chk("R10 fifo flushed", rxf_empty_o, 1);
    chk("R10 no frame_done", frame_done_o, 0);
    tick();
    chk("R10 listening", rx_active_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule